// File: doc/BRIEF.md
# Two-Key Watchdog Timer

The block is a watchdog for a processor subsystem. A counter runs on the system clock. If software does not service it before a selectable timeout passes, the block drives a short system reset pulse. Because the counter runs on that same clock, the watchdog cannot detect a clock that has stopped.

Servicing takes two writes to one service port. The first write, 0x55, arms the mechanism. A later write of 0xAA clears the counter and starts a fresh period. A stray single write therefore cannot keep a runaway program alive. A configuration input, normally fed from nonvolatile settings, turns the whole watchdog off while it is high. A two-bit rate input picks one of four timeout lengths, each a multiple of a base period.

Top module: `wdog_top`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `sys_rst_o` is low, the counter is zero and the sequence is disarmed.
- R2: With no valid service, `sys_rst_o` first rises at the clock edge that ends the L-th counting cycle. L is BASE_CYCLES times 1, 4, 16 or 64 for `rate_sel` values 0, 1, 2 and 3. Counting cycle 1 is the first edge after `rst` falls.
- R3: Each reset pulse on `sys_rst_o` is high for exactly PULSE_LEN (4) clock cycles.
- R4: After a pulse ends, the counter restarts from zero and the sequence is disarmed. Unserviced, the next pulse rises L+PULSE_LEN edges after the previous rise.
- R5: A write of 0x55 followed later by a write of 0xAA clears the counter at the 0xAA edge. The next timeout then comes L edges after that edge.
- R6: A write of 0xAA while disarmed has no effect on the counter or on the timeout time.
- R7: A write of any value other than 0x55 or 0xAA disarms the sequence. A repeated 0x55 keeps it armed.
- R8: While `wd_disable` is high, the counter is held at zero, no pulse starts and service writes are ignored. This includes 0x55, which leaves the sequence disarmed. After `wd_disable` falls with its first enabled edge E, the timeout comes at edge E+L-1.
- R9: A valid 0xAA write captured on the same edge as the timeout wins. No pulse starts and the counter clears.
- R10: If `rate_sel` changes to a length L whose limit the count already meets, the timeout happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_disable | input | 1 | Configuration bit; high turns the watchdog off |
| rate_sel | input | 2 | Timeout length select (x1, x4, x16, x64 of base) |
| svc_wr | input | 1 | Service port write strobe |
| svc_data | input | 8 | Service port write data |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench aims at the edge where the timeout meets a valid clearing write. A design that let expiry win would reset a correctly serviced system. It sends a lone 0xAA and a 0x55 broken by another value. A design that armed too loosely would accept these as a service and never time out. It also arms the sequence while the watchdog is disabled and then enables it. A design that kept that arm would take the first 0xAA as a service. Rate changes below the current count are covered too, where an equality-only compare would miss the limit and run on for a full wrap. The pulse width and the restart delay after a pulse are measured, which catches counters that are off by one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0] KEY_ARM = 8'h55;
    localparam logic [7:0] KEY_CLR = 8'hAA;
    localparam int unsigned NUM_RATES = 4;

    typedef enum logic [1:0] {
        RATE_X1  = 2'd0,
        RATE_X4  = 2'd1,
        RATE_X16 = 2'd2,
        RATE_X64 = 2'd3
    } rate_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
    } svc_req_t;

    function automatic int unsigned rate_mult(rate_e r);
        return 32'd1 << (2 * int'(r));
    endfunction

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     expire,
    input  svc_req_t req,
    output logic     armed_o,
    output logic     clear_o
);

    seq_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else if (!active || expire) begin
            state_q <= SEQ_IDLE;
        end else if (req.wr) begin
            if (req.data == KEY_ARM) begin
                state_q <= SEQ_ARMED;
            end else begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    assign armed_o = (state_q == SEQ_ARMED);
    assign clear_o = active && req.wr && (req.data == KEY_CLR) && (state_q == SEQ_ARMED);

endmodule

// File: rtl/wdog_tmo_cnt.sv
module wdog_tmo_cnt
    import wdog_pkg::*;
#(
    parameter int unsigned BASE  = 32,
    parameter int unsigned CNT_W = 11
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             clear,
    input  rate_e            rate,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] last_tab [NUM_RATES];
    logic [CNT_W-1:0] last_sel;
    logic [CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_last
        assign last_tab[g] = CNT_W'(BASE * rate_mult(rate_e'(g)) - 1);
    end

    assign last_sel = last_tab[rate];
    assign expire_o = active && !clear && (cnt_q >= last_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!active || clear || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int unsigned PULSE_LEN = 4,
    localparam int unsigned PW = $clog2(PULSE_LEN + 1)
)(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    output logic pulse_o
);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else if (expire) begin
            left_q <= PW'(PULSE_LEN);
        end
    end

    assign pulse_o = (left_q != '0);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 32,
    parameter int unsigned PULSE_LEN   = 4
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_disable,
    input  logic [1:0] rate_sel,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       sys_rst_o
);

    localparam int unsigned CNT_W = $clog2(BASE_CYCLES * 64);

    svc_req_t         req;
    logic             active;
    logic             expire;
    logic             clear_req;
    logic             armed;
    logic             pulse;
    logic [CNT_W-1:0] cnt_q;

    assign req.wr   = svc_wr;
    assign req.data = svc_data;
    assign active   = !wd_disable && !pulse;

    wdog_key_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .expire  (expire),
        .req     (req),
        .armed_o (armed),
        .clear_o (clear_req)
    );

    wdog_tmo_cnt #(
        .BASE  (BASE_CYCLES),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .clear    (clear_req),
        .rate     (rate_e'(rate_sel)),
        .cnt_o    (cnt_q),
        .expire_o (expire)
    );

    wdog_rst_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .pulse_o (pulse)
    );

    assign sys_rst_o = pulse;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int unsigned BASE      = 32,
    parameter int unsigned PULSE_LEN = 4,
    parameter int unsigned CNT_W     = 11
)(
    input logic             clk,
    input logic             rst,
    input logic             wd_disable,
    input logic             svc_wr,
    input logic [7:0]       svc_data,
    input logic             rst_out,
    input logic [CNT_W-1:0] cnt,
    input logic             armed,
    input logic             clear
);

    logic [7:0] hi_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len_q <= '0;
        end else if (rst_out) begin
            hi_len_q <= hi_len_q + 1'b1;
        end else begin
            hi_len_q <= '0;
        end
    end

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> (hi_len_q == 8'(PULSE_LEN)));

    // R3
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        hi_len_q <= 8'(PULSE_LEN));

    // R4
    pulse_state_chk: assert property (@(posedge clk) disable iff (rst)
        rst_out |-> (cnt == '0 && !armed));

    // R5
    service_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0 && !rst_out));

    // R6
    lone_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && svc_data == 8'hAA && !armed && !wd_disable && !rst_out)
        |=> ((cnt == CNT_W'($past(cnt) + 1)) || (cnt == '0 && rst_out)));

    // R7
    other_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && svc_data != 8'h55 && svc_data != 8'hAA) |=> !armed);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_disable && !rst_out) |=> (!rst_out && cnt == '0 && !armed));

endmodule

bind wdog_top wdog_chk #(
    .BASE      (BASE_CYCLES),
    .PULSE_LEN (PULSE_LEN),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wd_disable (wd_disable),
    .svc_wr     (svc_wr),
    .svc_data   (svc_data),
    .rst_out    (sys_rst_o),
    .cnt        (cnt_q),
    .armed      (armed),
    .clear      (clear_req)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 32;
    localparam int PLEN       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dis = 1'b0;
    logic [1:0] rate = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] data = 8'h00;
    logic       sys_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    int ec = 0;
    bit lock_en = 1'b1;

    int m_cnt = 0;
    int m_pulse = 0;
    bit m_armed = 1'b0;

    wdog_top #(.BASE_CYCLES(BASE), .PULSE_LEN(PLEN)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wd_disable (dis),
        .rate_sel   (rate),
        .svc_wr     (wr),
        .svc_data   (data),
        .sys_rst_o  (sys_rst_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int lim_of(input logic [1:0] r);
        return BASE * (1 << (2 * int'(r)));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model stepped on every edge from the requirements
    always @(posedge clk) begin
        bit act_m, clr_m, exp_m;
        if (rst) begin
            ec = 0; m_cnt = 0; m_pulse = 0; m_armed = 1'b0;
        end else begin
            ec = ec + 1;
            act_m = !dis && (m_pulse == 0);
            clr_m = act_m && wr && data == 8'hAA && m_armed;
            exp_m = act_m && !clr_m && (m_cnt >= lim_of(rate) - 1);
            if (!act_m || exp_m) m_armed = 1'b0;
            else if (wr) m_armed = (data == 8'h55);
            if (!act_m || clr_m || exp_m) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (m_pulse != 0) m_pulse = m_pulse - 1;
            else if (exp_m) m_pulse = PLEN;
        end
    end

    // Lockstep comparison of the reset output (R2 R3 R4 R5 R8)
    always @(negedge clk) begin
        if (lock_en) chk("R2/R5 lockstep sys_rst_o", int'(sys_rst_o), int'(m_pulse != 0));
    end

    task automatic do_reset(input logic [1:0] r, input logic d);
        @(negedge clk);
        rst = 1'b1; wr = 1'b0; rate = r; dis = d;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        while (ec < n) @(negedge clk);
    endtask

    task automatic wr_at(input int k, input logic [7:0] d);
        wait_edges(k);
        wr = 1'b1; data = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_rise(output int at, input int limit);
        at = -1;
        while (at < 0 && ec < limit) begin
            @(negedge clk);
            if (sys_rst_o) at = ec;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int at, at2, w, hi;
        void'($urandom(32'h5EED1234));

        // R1 reset state
        @(negedge clk);
        chk("R1 output in reset", int'(sys_rst_o), 0);
        do_reset(2'd0, 1'b0);
        chk("R1 output after release", int'(sys_rst_o), 0);

        // R2 timeout per rate
        for (int r = 0; r < 4; r++) begin
            do_reset(2'(r), 1'b0);
            wait_rise(at, 5000);
            chk($sformatf("R2 rise edge rate %0d", r), at, lim_of(2'(r)));
        end

        // R3 pulse width, R4 restart interval
        do_reset(2'd0, 1'b0);
        wait_rise(at, 500);
        w = 0;
        while (sys_rst_o) begin w++; @(negedge clk); end
        chk("R3 pulse width", w, PLEN);
        wait_rise(at2, 500);
        chk("R4 rise interval", at2 - at, BASE + PLEN);

        // R5 valid service
        do_reset(2'd0, 1'b0);
        wr_at(5, 8'h55);
        wr_at(20, 8'hAA);
        wait_rise(at, 500);
        chk("R5 rise after service", at, 21 + BASE);

        // R6 lone clearing key
        do_reset(2'd0, 1'b0);
        wr_at(10, 8'hAA);
        wait_rise(at, 500);
        chk("R6 lone AA ignored", at, BASE);

        // R7 other value disarms
        do_reset(2'd0, 1'b0);
        wr_at(3, 8'h55);
        wr_at(6, 8'h12);
        wr_at(9, 8'hAA);
        wait_rise(at, 500);
        chk("R7 broken sequence", at, BASE);

        // R7 repeated arm stays armed
        do_reset(2'd0, 1'b0);
        wr_at(3, 8'h55);
        wr_at(5, 8'h55);
        wr_at(8, 8'hAA);
        wait_rise(at, 500);
        chk("R7 double arm", at, 9 + BASE);

        // R9 service on the expiry edge
        do_reset(2'd0, 1'b0);
        wr_at(5, 8'h55);
        wr_at(BASE - 1, 8'hAA);
        wait_rise(at, 500);
        chk("R9 service beats expiry", at, 2 * BASE);

        // R10 rate lowered below the count
        do_reset(2'd3, 1'b0);
        wait_edges(100);
        rate = 2'd0;
        wait_rise(at, 500);
        chk("R10 immediate expiry", at, 101);

        // R8 disabled: quiet, arm ignored
        do_reset(2'd0, 1'b1);
        hi = 0;
        wr_at(2990, 8'h55);
        while (ec < 3000) begin
            @(negedge clk);
            if (sys_rst_o) hi++;
        end
        chk("R8 no pulse while disabled", hi, 0);
        dis = 1'b0;
        wr_at(3005, 8'hAA);
        wait_rise(at, 4000);
        chk("R8 rise after enable", at, 3001 + BASE - 1);

        // Random phase, checked by the lockstep model
        do_reset(2'd0, 1'b0);
        for (int i = 0; i < 8000; i++) begin
            int pick;
            @(negedge clk);
            wr = ($urandom % 4) == 0;
            pick = $urandom % 8;
            data = (pick < 3) ? 8'h55 : (pick < 6) ? 8'hAA : 8'($urandom);
            if ($urandom % 300 == 0) rate = 2'($urandom);
            if ($urandom % 1000 == 0) dis = ~dis;
            rst = ($urandom % 3000) == 0;
        end
        @(negedge clk);
        rst = 1'b0; wr = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule